// File: doc/BRIEF.md
# PCI Target Burst Data Controller

This block is the target-side data-phase engine of a 32-bit PCI agent. It watches the bus for an address phase, decides whether the transaction is a memory read or memory write aimed at its own address window, and then paces the burst that follows by driving DEVSEL# and TRDY#. Words written by the master go into a transmit buffer. Words read by the master come out of a receive buffer. Both buffers are seen as plain FIFO ports with an enable and a full or empty flag.

A word moves only on a clock edge where IRDY# and TRDY# are both low. The controller holds TRDY# high while the buffer for the current direction cannot keep up. It opens the FIFO enable only on a real transfer, so a master-side wait never pops or pushes a word. Only the buffer that matches the command is ever enabled. Any other command, or an address outside the window, is left unclaimed.

Top module: `pci_burst_target`

## Requirements
- R1: While reset is applied and after it is released with the bus idle, devsel_n and trdy_n are high, and tx_wr_en, rx_rd_en and ad_oe are low.
- R2: A memory write (C/BE# = 4'b0111 in the address phase) inside the window has devsel_n low in the clock after the address phase. That clock is already a data phase: trdy_n is low in it unless tx_full is high.
- R3: A memory read (C/BE# = 4'b0110) inside the window has one turnaround clock after the address phase. In that clock devsel_n is low, trdy_n is high, and ad_oe and rx_rd_en are low. Data phases begin on the following clock.
- R4: A word is pushed or popped only in a cycle where irdy_n and trdy_n are both low. With irdy_n high, tx_wr_en and rx_rd_en stay low.
- R5: During a write data phase, trdy_n follows tx_full: it is high, with no push, while tx_full is high, and the burst resumes once tx_full falls.
- R6: During a read data phase, trdy_n is high, with no pop, while rx_empty is high.
- R7: During a read, rx_rd_en is low in every cycle where irdy_n is high. In read data phases ad_oe is high and ad_out equals rx_rd_data.
- R8: On a push, tx_wr_data equals ad_in and tx_wr_be[i] equals the inverse of cbe_n[i] for each of the four byte lanes.
- R9: Commands other than memory read and memory write, and addresses whose bits above WIN_LOG2 differ from BASE_ADDR, are not claimed. devsel_n and trdy_n stay high and both enables stay low until the bus is idle again (frame_n and irdy_n high).
- R10: A transfer taken with frame_n high ends the burst. In the next clock devsel_n, trdy_n and ad_oe are released, and the controller accepts a new address phase.
- R11: devsel_n is low in every cycle where trdy_n is low, and tx_wr_en and rx_rd_en are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Transaction framing, active low |
| irdy_n | input | 1 | Master ready, active low |
| ad_in | input | 32 | Address and data from the bus |
| cbe_n | input | 4 | Command in the address phase, byte enables (active low) in data phases |
| ad_out | output | 32 | Read data towards the bus |
| ad_oe | output | 1 | High while the target drives ad_out |
| devsel_n | output | 1 | Target claims the transaction, active low |
| trdy_n | output | 1 | Target ready, active low |
| tx_wr_en | output | 1 | Push into the transmit buffer |
| tx_wr_data | output | 32 | Word pushed into the transmit buffer |
| tx_wr_be | output | 4 | Active-high byte lanes of the pushed word |
| tx_full | input | 1 | Transmit buffer cannot take a word |
| rx_rd_en | output | 1 | Pop from the receive buffer |
| rx_rd_data | input | 32 | Head word of the receive buffer (show-ahead) |
| rx_empty | input | 1 | Receive buffer has no word |

## Verification
The bench builds the block with BASE_ADDR = 32'h4000_0000 and WIN_LOG2 = 12, a 4 KiB window. These small values let it address the last word inside the window (32'h4000_0FFC) and the first word past it (32'h4000_1000), so both sides of the decode edge are exercised with ordinary addresses. Because the FIFO flags are direct bench inputs, a flag can be raised or dropped on any chosen data phase. This reaches every mix of master waits and target waits within a single burst.

// File: rtl/pci_tgt_pkg.sv
package pci_tgt_pkg;

  localparam logic [3:0] CMD_MEM_RD = 4'b0110;
  localparam logic [3:0] CMD_MEM_WR = 4'b0111;

  typedef enum logic [1:0] {
    ACC_NONE,
    ACC_WR,
    ACC_RD
  } access_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TURN,
    ST_WDATA,
    ST_RDATA,
    ST_SKIP
  } tgt_state_e;

endpackage

// File: rtl/pci_tgt_decode.sv
module pci_tgt_decode
  import pci_tgt_pkg::*;
#(
  parameter int          AW        = 32,
  parameter logic [31:0] BASE_ADDR = 32'h4000_0000,
  parameter int          WIN_LOG2  = 12
) (
  input  logic [AW-1:0] addr,
  input  logic [3:0]    cmd,
  output access_e       access
);

  localparam logic [AW-1:0] WIN_MASK = ~((AW'(1) << WIN_LOG2) - AW'(1));
  localparam logic [AW-1:0] WIN_BASE = BASE_ADDR[AW-1:0] & WIN_MASK;

  logic in_window;

  always_comb begin
    in_window = ((addr & WIN_MASK) == WIN_BASE);
    access    = ACC_NONE;
    if (in_window) begin
      if (cmd == CMD_MEM_WR)      access = ACC_WR;
      else if (cmd == CMD_MEM_RD) access = ACC_RD;
    end
  end

endmodule

// File: rtl/pci_tgt_lanes.sv
module pci_tgt_lanes #(
  parameter int LANES = 4
) (
  input  logic [8*LANES-1:0] bus_in,
  input  logic [LANES-1:0]   be_n,
  input  logic [8*LANES-1:0] rd_word,
  input  logic               drive,
  output logic [8*LANES-1:0] wr_word,
  output logic [LANES-1:0]   wr_be,
  output logic [8*LANES-1:0] bus_out
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign wr_word[8*g +: 8] = bus_in[8*g +: 8];
    assign wr_be[g]          = ~be_n[g];
    assign bus_out[8*g +: 8] = drive ? rd_word[8*g +: 8] : 8'h00;
  end

endmodule

// File: rtl/pci_tgt_fsm.sv
module pci_tgt_fsm
  import pci_tgt_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    frame_n,
  input  logic    irdy_n,
  input  access_e access,
  input  logic    tx_full,
  input  logic    rx_empty,
  output logic    devsel_n,
  output logic    trdy_n,
  output logic    ad_oe,
  output logic    tx_wr_en,
  output logic    rx_rd_en
);

  tgt_state_e state_q, state_d;
  logic       xfer;
  logic       bus_idle;

  always_comb begin
    bus_idle = frame_n && irdy_n;
    devsel_n = !((state_q == ST_TURN) || (state_q == ST_WDATA) ||
                 (state_q == ST_RDATA));
    unique case (state_q)
      ST_WDATA: trdy_n = tx_full;
      ST_RDATA: trdy_n = rx_empty;
      default:  trdy_n = 1'b1;
    endcase
    ad_oe    = (state_q == ST_RDATA);
    xfer     = !irdy_n && !trdy_n;
    tx_wr_en = xfer && (state_q == ST_WDATA);
    rx_rd_en = xfer && (state_q == ST_RDATA);
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (!frame_n && irdy_n) begin
          unique case (access)
            ACC_WR:  state_d = ST_WDATA;
            ACC_RD:  state_d = ST_TURN;
            default: state_d = ST_SKIP;
          endcase
        end
      end
      ST_TURN: state_d = ST_RDATA;
      ST_WDATA, ST_RDATA: begin
        if ((xfer && frame_n) || bus_idle) state_d = ST_IDLE;
      end
      ST_SKIP: if (bus_idle) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // R11
  property devsel_leads_trdy_p;
    @(posedge clk) disable iff (!rst_n) !trdy_n |-> !devsel_n;
  endproperty
  devsel_leads_trdy_chk: assert property (devsel_leads_trdy_p);

  // R11
  property one_buffer_p;
    @(posedge clk) disable iff (!rst_n) !(tx_wr_en && rx_rd_en);
  endproperty
  one_buffer_chk: assert property (one_buffer_p);

  // R7
  property no_pop_on_wait_p;
    @(posedge clk) disable iff (!rst_n) irdy_n |-> !rx_rd_en;
  endproperty
  no_pop_on_wait_chk: assert property (no_pop_on_wait_p);

  // R5
  property no_push_when_full_p;
    @(posedge clk) disable iff (!rst_n) tx_full |-> !tx_wr_en;
  endproperty
  no_push_when_full_chk: assert property (no_push_when_full_p);

  // R10
  property release_after_last_p;
    @(posedge clk) disable iff (!rst_n)
      ((tx_wr_en || rx_rd_en) && frame_n) |=> (devsel_n && trdy_n && !ad_oe);
  endproperty
  release_after_last_chk: assert property (release_after_last_p);

  // R3
  property turnaround_p;
    @(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && !frame_n && irdy_n && access == ACC_RD)
        |=> (!devsel_n && trdy_n && !ad_oe);
  endproperty
  turnaround_chk: assert property (turnaround_p);

endmodule

// File: rtl/pci_burst_target.sv
module pci_burst_target
  import pci_tgt_pkg::*;
#(
  parameter logic [31:0] BASE_ADDR = 32'h4000_0000,
  parameter int          WIN_LOG2  = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frame_n,
  input  logic        irdy_n,
  input  logic [31:0] ad_in,
  input  logic [3:0]  cbe_n,
  output logic [31:0] ad_out,
  output logic        ad_oe,
  output logic        devsel_n,
  output logic        trdy_n,
  output logic        tx_wr_en,
  output logic [31:0] tx_wr_data,
  output logic [3:0]  tx_wr_be,
  input  logic        tx_full,
  output logic        rx_rd_en,
  input  logic [31:0] rx_rd_data,
  input  logic        rx_empty
);

  localparam int LANES = 4;
  localparam int AW    = 8 * LANES;

  logic [1:0] rst_sync_q;
  logic       rst_core_n;
  access_e    access;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  pci_tgt_decode #(
    .AW        (AW),
    .BASE_ADDR (BASE_ADDR),
    .WIN_LOG2  (WIN_LOG2)
  ) i_decode (
    .addr   (ad_in),
    .cmd    (cbe_n),
    .access (access)
  );

  pci_tgt_fsm i_fsm (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .frame_n  (frame_n),
    .irdy_n   (irdy_n),
    .access   (access),
    .tx_full  (tx_full),
    .rx_empty (rx_empty),
    .devsel_n (devsel_n),
    .trdy_n   (trdy_n),
    .ad_oe    (ad_oe),
    .tx_wr_en (tx_wr_en),
    .rx_rd_en (rx_rd_en)
  );

  pci_tgt_lanes #(
    .LANES (LANES)
  ) i_lanes (
    .bus_in  (ad_in),
    .be_n    (cbe_n),
    .rd_word (rx_rd_data),
    .drive   (ad_oe),
    .wr_word (tx_wr_data),
    .wr_be   (tx_wr_be),
    .bus_out (ad_out)
  );

endmodule

// File: tb/test_pci_burst_target.sv
module test_pci_burst_target;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        frame_n, irdy_n, tx_full, rx_empty;
  logic [31:0] ad_in, rx_rd_data;
  logic [3:0]  cbe_n;
  logic [31:0] ad_out, tx_wr_data;
  logic [3:0]  tx_wr_be;
  logic        ad_oe, devsel_n, trdy_n, tx_wr_en, rx_rd_en;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  pci_burst_target #(
    .BASE_ADDR (32'h4000_0000),
    .WIN_LOG2  (12)
  ) i_pci_burst_target (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_n    (frame_n),
    .irdy_n     (irdy_n),
    .ad_in      (ad_in),
    .cbe_n      (cbe_n),
    .ad_out     (ad_out),
    .ad_oe      (ad_oe),
    .devsel_n   (devsel_n),
    .trdy_n     (trdy_n),
    .tx_wr_en   (tx_wr_en),
    .tx_wr_data (tx_wr_data),
    .tx_wr_be   (tx_wr_be),
    .tx_full    (tx_full),
    .rx_rd_en   (rx_rd_en),
    .rx_rd_data (rx_rd_data),
    .rx_empty   (rx_empty)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one bus clock: drive away from the edge, then let combinational outputs settle
  task automatic cyc(input logic f, input logic ir, input logic [31:0] a,
                     input logic [3:0] c, input logic full, input logic empty,
                     input logic [31:0] rdat);
    @(negedge clk);
    frame_n = f; irdy_n = ir; ad_in = a; cbe_n = c;
    tx_full = full; rx_empty = empty; rx_rd_data = rdat;
    #1;
  endtask

  task automatic quiet_cycle;
    cyc(1, 1, 32'h0, 4'hF, 0, 1, 32'h0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    frame_n = 1; irdy_n = 1; ad_in = 0; cbe_n = 4'hF;
    tx_full = 0; rx_empty = 1; rx_rd_data = 0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 devsel_n in reset", devsel_n, 1);
    chk("R1 trdy_n in reset", trdy_n, 1);
    rst_n = 1'b1;
    repeat (4) quiet_cycle();
    chk("R1 devsel_n idle", devsel_n, 1);
    chk("R1 trdy_n idle", trdy_n, 1);
    chk("R1 enables idle", {tx_wr_en, rx_rd_en, ad_oe}, 0);
  endtask

  task automatic t_write_burst;
    cyc(0, 1, 32'h4000_0100, 4'b0111, 0, 1, 0);
    chk("R2 not claimed in address phase", devsel_n, 1);
    cyc(0, 0, 32'hA1A2_A3A4, 4'b0000, 0, 1, 0);
    chk("R2 devsel_n first data", devsel_n, 0);
    chk("R2 trdy_n first data", trdy_n, 0);
    chk("R4 push on both ready", tx_wr_en, 1);
    chk("R8 write data", tx_wr_data, 32'hA1A2_A3A4);
    chk("R8 all lanes", tx_wr_be, 4'hF);
    cyc(0, 1, 32'hB1B2_B3B4, 4'b1010, 0, 1, 0);
    chk("R4 no push on master wait", tx_wr_en, 0);
    cyc(0, 0, 32'hB1B2_B3B4, 4'b1010, 1, 1, 0);
    chk("R5 trdy_n high when full", trdy_n, 1);
    chk("R5 no push when full", tx_wr_en, 0);
    chk("R11 devsel_n held during wait", devsel_n, 0);
    cyc(0, 0, 32'hB1B2_B3B4, 4'b1010, 0, 1, 0);
    chk("R5 resume after full", tx_wr_en, 1);
    chk("R8 partial lanes", tx_wr_be, 4'b0101);
    cyc(1, 0, 32'hC1C2_C3C4, 4'b0000, 0, 1, 0);
    chk("R10 last push", tx_wr_en, 1);
    chk("R8 last data", tx_wr_data, 32'hC1C2_C3C4);
    quiet_cycle();
    chk("R10 devsel_n released", devsel_n, 1);
    chk("R10 trdy_n released", trdy_n, 1);
    chk("R10 no push after end", tx_wr_en, 0);
  endtask

  task automatic t_read_burst;
    cyc(0, 1, 32'h4000_0200, 4'b0110, 0, 0, 32'h1111_0001);
    chk("R3 not claimed in address phase", devsel_n, 1);
    cyc(0, 0, 32'h0, 4'b0000, 0, 0, 32'h1111_0001);
    chk("R3 devsel_n in turnaround", devsel_n, 0);
    chk("R3 trdy_n in turnaround", trdy_n, 1);
    chk("R3 no drive or pop in turnaround", {ad_oe, rx_rd_en}, 0);
    cyc(0, 0, 32'h0, 4'b0000, 0, 0, 32'h1111_0001);
    chk("R3 trdy_n third clock", trdy_n, 0);
    chk("R7 ad_oe in read data", ad_oe, 1);
    chk("R7 ad_out", ad_out, 32'h1111_0001);
    chk("R4 pop", rx_rd_en, 1);
    cyc(0, 1, 32'h0, 4'b0000, 0, 0, 32'h2222_0002);
    chk("R7 no pop while irdy_n high", rx_rd_en, 0);
    cyc(0, 0, 32'h0, 4'b0000, 0, 1, 32'h2222_0002);
    chk("R6 trdy_n high when empty", trdy_n, 1);
    chk("R6 no pop when empty", rx_rd_en, 0);
    cyc(1, 0, 32'h0, 4'b0000, 0, 0, 32'h3333_0003);
    chk("R10 last pop", rx_rd_en, 1);
    chk("R7 last ad_out", ad_out, 32'h3333_0003);
    quiet_cycle();
    chk("R10 read released", {devsel_n, trdy_n, ad_oe}, 3'b110);
  endtask

  task automatic t_unclaimed(input logic [31:0] addr, input logic [3:0] cmd, input string tag);
    logic seen_claim = 1'b0;
    logic seen_en = 1'b0;
    cyc(0, 1, addr, cmd, 0, 0, 32'h5555_5555);
    for (int i = 0; i < 3; i++) begin
      cyc(i == 2, 0, 32'h6666_6666, 4'h0, 0, 0, 32'h5555_5555);
      seen_claim |= !devsel_n || !trdy_n;
      seen_en    |= tx_wr_en || rx_rd_en || ad_oe;
    end
    chk({"R9 no claim ", tag}, seen_claim, 0);
    chk({"R9 no enable ", tag}, seen_en, 0);
    quiet_cycle();
  endtask

  task automatic t_window_edge;
    cyc(0, 1, 32'h4000_0FFC, 4'b0111, 0, 1, 0);
    cyc(1, 0, 32'hDEAD_BEEF, 4'b1110, 0, 1, 0);
    chk("R9 last word in window claimed", devsel_n, 0);
    chk("R8 single-lane push", {tx_wr_en, tx_wr_be}, 5'b1_0001);
    quiet_cycle();
    chk("R10 single phase released", devsel_n, 1);
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_write_burst();
    quiet_cycle();
    t_read_burst();
    t_unclaimed(32'h4000_0100, 4'b0010, "io read");
    t_unclaimed(32'h4000_1000, 4'b0111, "above window");
    t_unclaimed(32'h3FFF_FFFC, 4'b0110, "below window");
    t_window_edge();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule